// File: doc/BRIEF.md
# Key-Protected DRAM Controller Configuration Register Bank

This block is the software-visible register bank of a DRAM controller's configuration side. A host reaches it over a plain word bus with a byte address, a write strobe, write data and read data. Only the register level is modelled: the block holds the words, shapes some of them as they are written, and returns them on reads. No memory traffic, PHY or scheduling logic is included.

All writes are protected by a key. One protection word at offset 0x00 can always be written. A write of the key value unlocks the bank and a write of any other value locks it again. While the bank is locked, every other write is dropped. The configuration word at offset 0x04 keeps its strap-derived read-only fields whatever software writes. The PHY status word at 0x60 never shows busy. The ECC self-test word at 0x70 always shows a finished, passing test. Reset loads the strap defaults and leaves the bank locked.

The decoded window is 4 KB, indexed by word address `addr[11:2]`. Only the first `NUM_WORDS` indices are backed by storage. Accesses to higher indices are ignored, and a write to one raises a one-cycle error flag.

Top module: `dcfg_regbank`

## Requirements
- R1: A write to offset 0x00 stores 1 if the data is exactly 0xFC600309, and stores 0 for any other value. This happens whether the bank is locked or not. The bank is unlocked while that word reads nonzero.
- R2: While the protection word reads 0, a write to any other offset leaves every stored value unchanged.
- R3: On an unlocked write to offset 0x04, the bits in the read-only mask 0xF00FC04C are replaced by the fixed configuration value, and the other bits take the written data. The read-only mask covers bits 31:28, 19:14, 6 and 3:2. Bits 1:0 are stored as the write data ORed with the size code.
- R4: The fixed configuration value has `HW_VERSION` in bits 31:28, a 1 in bit 19, code 3 in bits 3:2, and the size code in bits 1:0. The size code is 0, 1, 2 or 3 for `MEM_SIZE_MB` values of 128, 256, 512 or 1024. Any other size uses code 2. With the defaults the value is 0x1008000E.
- R5: On an unlocked write to offset 0x60, bit 0 is stored as 0 and the other bits take the written data.
- R6: On an unlocked write to offset 0x70, bit 12 is stored as 1, bit 13 is stored as 0, and the other bits take the written data.
- R7: After reset, offset 0x04 holds the fixed configuration value, every other word holds 0, and the bank is locked.
- R8: A word index `addr[11:2]` at or above `NUM_WORDS` reads as 0, and a write to it changes no stored word. Such a write drives `range_err` high for exactly the one cycle after the write edge.
- R9: Any other in-range offset stores the written data unchanged on an unlocked write.
- R10: `rd_data` shows the word at `addr` combinationally, and it reflects a write from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address; bits 11:2 select the word |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (0 when out of range) |
| range_err | output | 1 | One-cycle pulse after a write to an unbacked index |

## Verification
Reads are combinational, so a value that a write stores shows on `rd_data` right after the write edge. The bench drives each write on a falling edge and holds it through one rising edge. It then moves the address and compares `rd_data` a moment later, before the next rising edge. `range_err` comes from a register and is due in the cycle after the offending write edge, so the bench samples it at the falling edge that ends the write, and samples it one cycle later again to confirm the pulse has ended. Two extra instances with other size parameters are checked only in their reset state, since the size code is fixed at build time.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;

    localparam logic [31:0] UNLOCK_KEY  = 32'hFC60_0309;
    localparam logic [31:0] CONF_RO_MSK = 32'hF00F_C04C;

    localparam int IDX_PROT = 'h00;
    localparam int IDX_CONF = 'h01;
    localparam int IDX_STAT = 'h18;
    localparam int IDX_ECC  = 'h1C;

    typedef enum logic [2:0] {
        K_PROT,
        K_CONF,
        K_STAT,
        K_ECC,
        K_PLAIN
    } reg_kind_e;

    function automatic logic [1:0] size_code(input int mb);
        case (mb)
            128:     return 2'd0;
            256:     return 2'd1;
            512:     return 2'd2;
            1024:    return 2'd3;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [31:0] fixed_conf(input int hw, input int mb);
        logic [31:0] v;
        v        = '0;
        v[31:28] = hw[3:0];
        v[19]    = 1'b1;
        v[3:2]   = 2'd3;
        v[1:0]   = size_code(mb);
        return v;
    endfunction

endpackage

// File: rtl/dcfg_decode.sv
module dcfg_decode #(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 512,
    localparam int IDX_W    = ADDR_W - 2,
    localparam int MEM_AW   = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                in_range,
    output logic [MEM_AW-1:0]   mem_idx,
    output dcfg_pkg::reg_kind_e kind
);
    import dcfg_pkg::*;

    logic [IDX_W-1:0] word_idx;
    logic [1:0]       unused_byte_lane;

    assign word_idx         = addr[ADDR_W-1:2];
    assign unused_byte_lane = addr[1:0];
    assign in_range         = (int'(word_idx) < NUM_WORDS);
    assign mem_idx          = word_idx[MEM_AW-1:0];

    always_comb begin
        case (int'(word_idx))
            IDX_PROT: kind = K_PROT;
            IDX_CONF: kind = K_CONF;
            IDX_STAT: kind = K_STAT;
            IDX_ECC:  kind = K_ECC;
            default:  kind = K_PLAIN;
        endcase
    end
endmodule

// File: rtl/dcfg_shaper.sv
module dcfg_shaper #(
    parameter logic [31:0] FIXED = 32'h1008_000E
) (
    input  dcfg_pkg::reg_kind_e kind,
    input  logic [31:0]         data,
    input  logic                unlocked,
    output logic                allow,
    output logic [31:0]         word
);
    import dcfg_pkg::*;

    always_comb begin
        allow = unlocked;
        word  = data;
        case (kind)
            K_PROT: begin
                allow = 1'b1;
                word  = {31'b0, data == UNLOCK_KEY};
            end
            K_CONF:  word = (data & ~CONF_RO_MSK) | FIXED;
            K_STAT:  word[0] = 1'b0;
            K_ECC: begin
                word[12] = 1'b1;
                word[13] = 1'b0;
            end
            default: word = data;
        endcase
    end
endmodule

// File: rtl/dcfg_store.sv
module dcfg_store #(
    parameter int          NUM_WORDS = 512,
    parameter logic [31:0] FIXED     = 32'h1008_000E,
    localparam int         MEM_AW    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MEM_AW-1:0] widx,
    input  logic [31:0]       wword,
    input  logic [MEM_AW-1:0] ridx,
    output logic [31:0]       rword,
    output logic              unlocked,
    output logic [31:0]       conf_q,
    output logic [31:0]       stat_q,
    output logic [31:0]       ecc_q
);
    import dcfg_pkg::*;

    logic [31:0] mem [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                mem[i] <= (i == IDX_CONF) ? FIXED : 32'h0;
            end
        end else if (we) begin
            mem[widx] <= wword;
        end
    end

    assign rword    = mem[ridx];
    assign unlocked = |mem[IDX_PROT];
    assign conf_q   = mem[IDX_CONF];
    assign stat_q   = mem[IDX_STAT];
    assign ecc_q    = mem[IDX_ECC];
endmodule

// File: rtl/dcfg_regbank.sv
module dcfg_regbank #(
    parameter int ADDR_W      = 12,
    parameter int NUM_WORDS   = 512,
    parameter int HW_VERSION  = 1,
    parameter int MEM_SIZE_MB = 512,
    localparam int MEM_AW     = $clog2(NUM_WORDS),
    localparam logic [31:0] FIXED = dcfg_pkg::fixed_conf(HW_VERSION, MEM_SIZE_MB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              range_err
);
    import dcfg_pkg::*;

    logic              in_range;
    logic [MEM_AW-1:0] mem_idx;
    reg_kind_e         kind;
    logic              allow;
    logic [31:0]       shaped;
    logic              unlocked;
    logic [31:0]       rword;
    logic [31:0]       conf_q;
    logic [31:0]       stat_q;
    logic [31:0]       ecc_q;
    logic              store_we;

    dcfg_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
        .addr(addr), .in_range(in_range), .mem_idx(mem_idx), .kind(kind)
    );

    dcfg_shaper #(.FIXED(FIXED)) u_shp (
        .kind(kind), .data(wr_data), .unlocked(unlocked),
        .allow(allow), .word(shaped)
    );

    assign store_we = wr_en && in_range && allow;

    dcfg_store #(.NUM_WORDS(NUM_WORDS), .FIXED(FIXED)) u_store (
        .clk(clk), .rst(rst), .we(store_we), .widx(mem_idx), .wword(shaped),
        .ridx(mem_idx), .rword(rword), .unlocked(unlocked),
        .conf_q(conf_q), .stat_q(stat_q), .ecc_q(ecc_q)
    );

    assign rd_data = in_range ? rword : 32'h0;

    always_ff @(posedge clk) begin
        if (rst) range_err <= 1'b0;
        else     range_err <= wr_en && !in_range;
    end

    // R1: protection word follows the key comparison
    p_key_store_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_range && kind == K_PROT)
        |=> (unlocked == ($past(wr_data) == UNLOCK_KEY)));

    // R2: locked write leaves the addressed word's read value intact
    p_lock_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_range && kind != K_PROT && !unlocked)
        |=> (addr != $past(addr) || rd_data == $past(rd_data)));

    // R3: read-only configuration fields always match the straps
    p_conf_ro_r3: assert property (@(posedge clk) disable iff (rst)
        ((conf_q & CONF_RO_MSK) == (FIXED & CONF_RO_MSK)));

    // R5: PHY status never reads busy
    p_phy_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !stat_q[0]);

    // R6: ECC test word reports finished and passed after a write
    p_ecc_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_range && kind == K_ECC && unlocked)
        |=> (ecc_q[12] && !ecc_q[13]));

    // R8: error flag follows an out-of-range write by one cycle
    p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_range) |=> range_err);
    p_err_only_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && !in_range) |=> !range_err);
endmodule

// File: tb/dcfg_regbank_bench.sv
module dcfg_regbank_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data, rd_a, rd_b;
    logic        range_err, err_a, err_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dcfg_regbank u_dcfg_regbank (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .range_err(range_err)
    );

    dcfg_regbank #(.MEM_SIZE_MB(384)) u_alt_a (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(1'b0), .wr_data(wr_data),
        .rd_data(rd_a), .range_err(err_a)
    );

    dcfg_regbank #(.MEM_SIZE_MB(1024)) u_alt_b (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(1'b0), .wr_data(wr_data),
        .rd_data(rd_b), .range_err(err_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(12'h000, v); chk("R7 prot", v, 32'h0);
        rd(12'h004, v); chk("R7 conf", v, 32'h1008_000E);
        rd(12'h060, v); chk("R7 stat", v, 32'h0);
        rd(12'h070, v); chk("R7 ecc", v, 32'h0);
        rd(12'h100, v); chk("R7 plain", v, 32'h0);
        chk("R7 range_err", {31'b0, range_err}, 32'h0);
        addr = 12'h004; #0.5;
        chk("R4 fallback 384MB", rd_a, 32'h1008_000E);
        chk("R4 1024MB", rd_b, 32'h1008_000F);
        chk("R4 default 512MB", rd_data, 32'h1008_000E);
    endtask

    task automatic t_locked();
        logic [31:0] v;
        wr(12'h008, 32'hAAAA_5555);
        rd(12'h008, v); chk("R2 plain locked", v, 32'h0);
        wr(12'h004, 32'h0000_0000);
        rd(12'h004, v); chk("R2 conf locked", v, 32'h1008_000E);
        wr(12'h060, 32'h1234_0000);
        rd(12'h060, v); chk("R2 stat locked", v, 32'h0);
    endtask

    task automatic t_key();
        logic [31:0] v;
        wr(12'h000, 32'hFC60_0308);
        rd(12'h000, v); chk("R1 wrong key", v, 32'h0);
        wr(12'h000, 32'hFC60_0309);
        rd(12'h000, v); chk("R1 right key", v, 32'h1);
        wr(12'h000, 32'hFC60_0309);
        rd(12'h000, v); chk("R1 key again", v, 32'h1);
    endtask

    task automatic t_plain();
        logic [31:0] v;
        wr(12'h008, 32'hAAAA_5555);
        rd(12'h008, v); chk("R9 plain 0x08", v, 32'hAAAA_5555);
        wr(12'h7FC, 32'h1234_5678);
        rd(12'h7FC, v); chk("R9 last word", v, 32'h1234_5678);
        @(negedge clk);
        addr = 12'h00C; wr_data = 32'h0BAD_F00D; wr_en = 1'b1;
        @(posedge clk); #0.5;
        wr_en = 1'b0;
        chk("R10 visible after edge", rd_data, 32'h0BAD_F00D);
    endtask

    task automatic t_conf();
        logic [31:0] v;
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, v); chk("R3 conf ones", v, 32'h1FF8_3FBF);
        wr(12'h004, 32'h0000_0000);
        rd(12'h004, v); chk("R3 conf zeros", v, 32'h1008_000E);
        wr(12'h004, 32'h0000_0001);
        rd(12'h004, v); chk("R3 size bit0", v, 32'h1008_000F);
    endtask

    task automatic t_status();
        logic [31:0] v;
        wr(12'h060, 32'hFFFF_FFFF);
        rd(12'h060, v); chk("R5 stat ones", v, 32'hFFFF_FFFE);
        wr(12'h070, 32'hFFFF_FFFF);
        rd(12'h070, v); chk("R6 ecc ones", v, 32'hFFFF_DFFF);
        wr(12'h070, 32'h0000_0000);
        rd(12'h070, v); chk("R6 ecc zeros", v, 32'h0000_1000);
    endtask

    task automatic t_range();
        logic [31:0] v;
        @(negedge clk);
        addr = 12'h804; wr_data = 32'h0000_DEAD; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 err pulse", {31'b0, range_err}, 32'h1);
        @(negedge clk);
        chk("R8 err clears", {31'b0, range_err}, 32'h0);
        rd(12'h804, v); chk("R8 oob read", v, 32'h0);
        rd(12'h004, v); chk("R8 no alias conf", v, 32'h1008_000F);
        wr(12'h010, 32'h5);
        chk("R8 no err in range", {31'b0, range_err}, 32'h0);
    endtask

    task automatic t_relock();
        logic [31:0] v;
        wr(12'h000, 32'h0);
        rd(12'h000, v); chk("R1 relock", v, 32'h0);
        wr(12'h008, 32'h1111_2222);
        rd(12'h008, v); chk("R2 after relock", v, 32'hAAAA_5555);
    endtask

    initial begin
        t_reset();
        t_locked();
        t_key();
        t_plain();
        t_conf();
        t_status();
        t_range();
        t_relock();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule